// File: doc/BRIEF.md
# Converter Pre-Trigger Channel with Sequence-Error Tracking

This block is one channel of a programmable delay unit. It drives eight pre-trigger pulses toward a single analog-to-digital converter. Each pre-trigger slot has an enable, a mode select and a chain option. In bypass mode a slot pulses one clock after a trigger event. A trigger event is a rising edge on the hardware trigger input or a software strobe. In delay mode a slot pulses once, one clock after the shared counter reaches that slot's own 16-bit delay. In chained delay mode a slot pulses one clock after the converter finishes a conversion that its predecessor slot started.

The channel records which slot owns the conversion currently in the converter. A pulse issued while that conversion is still running is rejected by the converter, and the channel sets that slot's sequence-error bit. A separate match flag per slot records that the counter reached the slot's delay. Both flag sets are cleared by writing zeros through a keep-mask strobe. The counter itself and the buffering of the settings are outside this block.

Top module: `pretrig_channel`

## Requirements
- R1: After reset, `pretrig`, `seq_err` and `match_flag` are all zero.
- R2: A slot with `slot_en`=1 and `slot_sel`=0 (bypass) pulses `pretrig` for one cycle, on the cycle after a trigger event. A trigger event is `trig_in` sampled high after being sampled low, or `sw_strobe` sampled high. A level that stays high on `trig_in` gives no further pulses.
- R3: A slot with `slot_en`=1, `slot_sel`=1 and `slot_chain`=0 pulses on the cycle after a clock edge that samples `cnt_run`=1 and `cnt` equal to its delay. Its delay is bits [16m+15:16m] of `slot_dly`. It pulses at most once between trigger events.
- R4: A conflict exists when a clock edge samples `conv_busy`=1 and `conv_done`=0 while the channel owns a conversion. On such an edge, every slot that fires still pulses, and its `seq_err` bit is set on the same edge.
- R5: When several slots fire on one edge with no conflict, the lowest-numbered slot takes ownership. Every other slot that fires gets its `seq_err` bit set.
- R6: On an edge with `err_wr`=1, each `seq_err` bit whose `err_keep` bit is 0 is cleared and the others are kept. A new error on the same edge still sets its bit.
- R7: `match_flag[m]` sets on an edge that samples `cnt_run`=1 with `cnt` equal to slot m's delay, whether or not the slot is enabled. On an edge with `flag_wr`=1, each bit whose `flag_keep` bit is 0 is cleared.
- R8: A slot with `slot_en`, `slot_sel` and `slot_chain` all set does not fire on its delay match. It pulses on the cycle after an edge that samples `conv_done`=1 while the channel owns a conversion started by slot m-1. For slot 0 that predecessor is slot 7.
- R9: A slot with `slot_en`=0 never pulses and never sets its `seq_err` bit.
- R10: `conv_done` ends ownership. A slot that fires on the same edge as `conv_done` is accepted without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_en | input | 8 | Per-slot enable |
| slot_sel | input | 8 | Per-slot mode: 0 bypass, 1 delay |
| slot_chain | input | 8 | Per-slot chain option (delay mode only) |
| slot_dly | input | 128 | Delays, slot m at bits [16m+15:16m] |
| cnt | input | 16 | Shared counter value |
| cnt_run | input | 1 | Counter running after a trigger |
| trig_in | input | 1 | Hardware trigger level |
| sw_strobe | input | 1 | Software trigger strobe |
| conv_busy | input | 1 | Converter busy |
| conv_done | input | 1 | Conversion-complete pulse |
| err_wr | input | 1 | Error flag write strobe |
| err_keep | input | 8 | Error flag keep mask (0 clears) |
| flag_wr | input | 1 | Match flag write strobe |
| flag_keep | input | 8 | Match flag keep mask (0 clears) |
| pretrig | output | 8 | Pre-trigger pulses |
| seq_err | output | 8 | Sequence-error flags |
| match_flag | output | 8 | Delay-match flags |

## Verification
The assertions assume two things about the converter side. `conv_done` is a one-cycle pulse, and the converter raises `conv_busy` only for conversions it actually accepted. The bench plays the converter by hand. It raises busy after an accepted pulse and issues done pulses that never overlap a second done. The counter is driven as a monotonic sweep that starts after a trigger event, so each delay value is seen once per sweep. This matches the single-shot assumption behind the per-slot "already fired" state.

// File: rtl/pretrig_pkg.sv
// Shared helpers for the pre-trigger channel.
// Assumes slot indices run from 0 to n-1 and wrap around.
package pretrig_pkg;
    // Predecessor slot used by the chain option; slot 0 wraps to n-1.
    function automatic int unsigned prev_slot(input int unsigned m, input int unsigned n);
        return (m + n - 1) % n;
    endfunction
endpackage

// File: rtl/pretrig_slot.sv
// One pre-trigger slot: picks bypass, delay-match or chain firing and keeps its match flag.
// Assumes the counter sweeps each value at most once per trigger event.
module pretrig_slot #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sel,
    input  logic             chain,
    input  logic [DLY_W-1:0] dly,
    input  logic [DLY_W-1:0] cnt,
    input  logic             cnt_run,
    input  logic             trig_evt,
    input  logic             chain_go,
    input  logic             flag_wr,
    input  logic             flag_keep,
    output logic             fire_nxt,
    output logic             fire_q,
    output logic             match_flag
);
    logic spent;
    logic at_dly;
    logic dly_hit;

    assign at_dly  = cnt_run && (cnt == dly);
    assign dly_hit = at_dly && !spent;

    // Select the firing source for this slot, masked by its enable.
    always_comb begin
        if (!en)
            fire_nxt = 1'b0;
        else if (!sel)
            fire_nxt = trig_evt;
        else if (chain)
            fire_nxt = chain_go;
        else
            fire_nxt = dly_hit;
    end

    // Register the pulse and remember a delay hit until the next trigger event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_q <= 1'b0;
            spent  <= 1'b0;
        end else begin
            fire_q <= fire_nxt;
            spent  <= trig_evt ? 1'b0 : (spent | dly_hit);
        end
    end

    // Match flag: set on reaching the delay, cleared by a zero in the keep mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_flag <= 1'b0;
        else
            match_flag <= (match_flag & (flag_wr ? flag_keep : 1'b1)) | at_dly;
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !fire_q); // R9
    AST_BYPASS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sel && trig_evt) |=> fire_q); // R2
    AST_CHAIN_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sel && chain && !chain_go) |=> !fire_q); // R8
    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        at_dly |=> match_flag); // R7
endmodule

// File: rtl/pretrig_arbiter.sv
// Tracks conversion ownership and sets per-slot sequence errors.
// Assumes conv_done is a single-cycle pulse and conv_busy reflects only accepted conversions.
module pretrig_arbiter #(
    parameter int N_SLOT = 8,
    localparam int IDX_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SLOT-1:0] fire_vec,
    input  logic              conv_busy,
    input  logic              conv_done,
    input  logic              err_wr,
    input  logic [N_SLOT-1:0] err_keep,
    output logic [N_SLOT-1:0] err_q,
    output logic              own_active,
    output logic [IDX_W-1:0]  owner
);
    logic              conflict;
    logic [N_SLOT-1:0] accept;
    logic [N_SLOT-1:0] new_err;
    logic [IDX_W-1:0]  win_idx;

    assign conflict = own_active && conv_busy && !conv_done;

    // Pick the lowest-numbered firing slot as the accepted one.
    always_comb begin
        accept  = '0;
        win_idx = '0;
        if (!conflict) begin
            for (int i = N_SLOT - 1; i >= 0; i--) begin
                if (fire_vec[i]) begin
                    accept  = '0;
                    accept[i] = 1'b1;
                    win_idx = IDX_W'(i);
                end
            end
        end
        new_err = fire_vec & ~accept;
    end

    // Error flags: zeros in the keep mask clear, new errors set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= '0;
        else
            err_q <= (err_q & (err_wr ? err_keep : {N_SLOT{1'b1}})) | new_err;
    end

    // Ownership: taken by an accepted pulse, released by conversion complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_active <= 1'b0;
            owner      <= '0;
        end else if (accept != '0) begin
            own_active <= 1'b1;
            owner      <= win_idx;
        end else if (conv_done) begin
            own_active <= 1'b0;
        end
    end

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(accept)); // R5
    AST_CONFLICT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict && fire_vec != '0) |=> ((err_q & $past(fire_vec)) == $past(fire_vec))); // R4
    AST_ERR_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q & ~$past(err_q) & ~$past(fire_vec)) == '0); // R9
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && fire_vec == '0) |=> !own_active); // R10
endmodule

// File: rtl/pretrig_channel.sv
// Pre-trigger channel top: trigger edge detection, per-slot generators, ownership arbiter.
// Assumes cnt/cnt_run come from a shared counter that starts on a trigger event.
module pretrig_channel #(
    parameter int N_SLOT = 8,
    parameter int DLY_W  = 16,
    localparam int IDX_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SLOT-1:0]       slot_en,
    input  logic [N_SLOT-1:0]       slot_sel,
    input  logic [N_SLOT-1:0]       slot_chain,
    input  logic [N_SLOT*DLY_W-1:0] slot_dly,
    input  logic [DLY_W-1:0]        cnt,
    input  logic                    cnt_run,
    input  logic                    trig_in,
    input  logic                    sw_strobe,
    input  logic                    conv_busy,
    input  logic                    conv_done,
    input  logic                    err_wr,
    input  logic [N_SLOT-1:0]       err_keep,
    input  logic                    flag_wr,
    input  logic [N_SLOT-1:0]       flag_keep,
    output logic [N_SLOT-1:0]       pretrig,
    output logic [N_SLOT-1:0]       seq_err,
    output logic [N_SLOT-1:0]       match_flag
);
    import pretrig_pkg::*;

    logic              trig_q;
    logic              trig_evt;
    logic              own_active;
    logic [IDX_W-1:0]  owner;
    logic [N_SLOT-1:0] fire_vec;
    logic [N_SLOT-1:0] chain_go;

    // Remember the trigger level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_q <= 1'b0;
        else
            trig_q <= trig_in;
    end

    assign trig_evt = (trig_in && !trig_q) || sw_strobe;

    for (genvar m = 0; m < N_SLOT; m++) begin : g_slot
        assign chain_go[m] = conv_done && own_active &&
                             (owner == IDX_W'(prev_slot(m, N_SLOT)));

        pretrig_slot #(.DLY_W(DLY_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (slot_en[m]),
            .sel        (slot_sel[m]),
            .chain      (slot_chain[m]),
            .dly        (slot_dly[m*DLY_W +: DLY_W]),
            .cnt        (cnt),
            .cnt_run    (cnt_run),
            .trig_evt   (trig_evt),
            .chain_go   (chain_go[m]),
            .flag_wr    (flag_wr),
            .flag_keep  (flag_keep[m]),
            .fire_nxt   (fire_vec[m]),
            .fire_q     (pretrig[m]),
            .match_flag (match_flag[m])
        );
    end

    pretrig_arbiter #(.N_SLOT(N_SLOT)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_vec   (fire_vec),
        .conv_busy  (conv_busy),
        .conv_done  (conv_done),
        .err_wr     (err_wr),
        .err_keep   (err_keep),
        .err_q      (seq_err),
        .own_active (own_active),
        .owner      (owner)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (pretrig == '0 && seq_err == '0 && match_flag == '0)); // R1
endmodule

// File: tb/pretrig_channel_bench.sv
module pretrig_channel_bench;
    localparam int N = 8;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   slot_en = '0, slot_sel = '0, slot_chain = '0;
    logic [N*W-1:0] slot_dly = '0;
    logic [W-1:0]   cnt = '0;
    logic           cnt_run = 1'b0, trig_in = 1'b0, sw_strobe = 1'b0;
    logic           conv_busy = 1'b0, conv_done = 1'b0;
    logic           err_wr = 1'b0, flag_wr = 1'b0;
    logic [N-1:0]   err_keep = '0, flag_keep = '0;
    logic [N-1:0]   pretrig, seq_err, match_flag;

    int n_cmp = 0;
    int n_bad = 0;

    pretrig_channel u_pretrig_channel (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_sel(slot_sel),
        .slot_chain(slot_chain), .slot_dly(slot_dly), .cnt(cnt), .cnt_run(cnt_run),
        .trig_in(trig_in), .sw_strobe(sw_strobe), .conv_busy(conv_busy),
        .conv_done(conv_done), .err_wr(err_wr), .err_keep(err_keep),
        .flag_wr(flag_wr), .flag_keep(flag_keep), .pretrig(pretrig),
        .seq_err(seq_err), .match_flag(match_flag)
    );

    always #4 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic strobe();
        sw_strobe = 1'b1;
        tick();
        sw_strobe = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [N-1:0] exp_mask;
        tick(); tick();
        check("R1 pretrig", pretrig, '0);
        check("R1 seq_err", seq_err, '0);
        check("R1 match", match_flag, '0);
        rst_n = 1'b1;
        tick();

        // R2: bypass sweep, one slot at a time, software strobe and hardware edge
        for (int m = 0; m < N; m++) begin
            slot_en = N'(1) << m;
            conv_done = 1'b1;            // release ownership from the previous slot
            strobe();
            conv_done = 1'b0;
            check($sformatf("R2 strobe slot%0d", m), pretrig, N'(1) << m);
            tick();
            check($sformatf("R2 single slot%0d", m), pretrig, '0);
        end
        slot_en = 8'hFF;
        conv_done = 1'b1; tick(); conv_done = 1'b0;
        trig_in = 1'b1; tick();
        check("R2 rising edge", pretrig, 8'hFF);
        tick();
        check("R2 held level", pretrig, '0);
        trig_in = 1'b0;
        err_wr = 1'b1; err_keep = '0; tick(); err_wr = 1'b0;
        conv_done = 1'b1; tick(); conv_done = 1'b0;

        // R3/R7: delay-mode sweep with delay 3m+2
        slot_sel = 8'hFF;
        for (int m = 0; m < N; m++) slot_dly[m*W +: W] = W'(3 * m + 2);
        flag_wr = 1'b1; flag_keep = '0; tick(); flag_wr = 1'b0;
        strobe();
        for (int c = 0; c < 30; c++) begin
            cnt = W'(c); cnt_run = 1'b1;
            tick();
            exp_mask = '0;
            for (int m = 0; m < N; m++) if (3 * m + 2 == c) exp_mask[m] = 1'b1;
            check($sformatf("R3 cnt=%0d", c), pretrig, exp_mask);
        end
        cnt_run = 1'b0;
        check("R3 no conflict errors", seq_err, '0);
        check("R7 all flags set", match_flag, 8'hFF);
        for (int c = 0; c < 30; c++) begin
            cnt = W'(c); cnt_run = 1'b1;
            tick();
            check($sformatf("R3 once cnt=%0d", c), pretrig, '0);
        end
        cnt_run = 1'b0;
        flag_wr = 1'b1; flag_keep = 8'h0F; tick(); flag_wr = 1'b0;
        check("R7 keep-mask clear", match_flag, 8'h0F);
        // R7 flag sets for a disabled slot too
        slot_en = '0; flag_wr = 1'b1; flag_keep = '0; tick(); flag_wr = 1'b0;
        cnt = W'(5); cnt_run = 1'b1; tick(); cnt_run = 1'b0;
        check("R7 disabled slot flag", match_flag, 8'h02);
        check("R9 disabled delay hit", pretrig, '0);

        // R5/R4/R6/R10: ownership and errors
        slot_sel = '0; slot_en = 8'h03;
        conv_done = 1'b1; tick(); conv_done = 1'b0;
        strobe();
        check("R5 both pulse", pretrig, 8'h03);
        check("R5 loser error", seq_err, 8'h02);
        conv_busy = 1'b1;
        strobe();
        check("R4 conflict pulses", pretrig, 8'h03);
        check("R4 conflict errors", seq_err, 8'h03);
        err_wr = 1'b1; err_keep = 8'h01; tick(); err_wr = 1'b0;
        check("R6 partial clear", seq_err, 8'h01);
        err_wr = 1'b1; err_keep = 8'h00; sw_strobe = 1'b1; slot_en = 8'h02;
        tick();
        err_wr = 1'b0; sw_strobe = 1'b0;
        check("R6 set beats clear", seq_err, 8'h02);
        err_wr = 1'b1; err_keep = '0; tick(); err_wr = 1'b0;
        slot_en = 8'h01; conv_done = 1'b1; sw_strobe = 1'b1;
        tick();
        conv_done = 1'b0; sw_strobe = 1'b0;
        check("R10 accepted on done", pretrig, 8'h01);
        check("R10 no error", seq_err, '0);
        slot_en = '0; strobe();
        check("R9 disabled pulse", pretrig, '0);
        check("R9 disabled error", seq_err, '0);

        // R8: chain slot2 after slot1, then slot0 after slot7 (wrap)
        conv_busy = 1'b0; conv_done = 1'b1; tick(); conv_done = 1'b0;
        slot_en = 8'h06; slot_sel = 8'h04; slot_chain = 8'h04;
        slot_dly[2*W +: W] = W'(9);
        strobe();
        check("R8 predecessor", pretrig, 8'h02);
        conv_busy = 1'b1;
        cnt = W'(9); cnt_run = 1'b1; tick(); cnt_run = 1'b0;
        check("R8 no delay fire", pretrig, '0);
        conv_done = 1'b1; tick(); conv_done = 1'b0;
        check("R8 chained fire", pretrig, 8'h04);
        conv_done = 1'b1; tick(); conv_done = 1'b0;
        check("R8 no refire", pretrig, '0);
        check("R8 no error", seq_err, '0);
        conv_busy = 1'b0;
        slot_en = 8'h81; slot_sel = 8'h01; slot_chain = 8'h01;
        strobe();
        check("R8 wrap predecessor", pretrig, 8'h80);
        conv_done = 1'b1; tick(); conv_done = 1'b0;
        check("R8 wrap chained", pretrig, 8'h01);

        report();
    end
endmodule